// File: doc/BRIEF.md
# Event Timer Comparator Channel

One channel of a multi-channel event timer. The channel watches a shared free-running main counter and produces a one-clock expiry strobe when the counter reaches its comparator. It runs in one of two modes. In one-shot mode it fires once per match. In periodic mode the comparator steps forward by a programmed period after every match. A narrow mode compares only the low half of the counter, so a half-width timer can run against a full-width counter.

Software reaches the channel through three half-width write strobes that share one data bus: one for the configuration word, one for the low comparator half and one for the high comparator half. The configuration, comparator and period registers are always visible on readback outputs. In periodic mode a comparator write normally changes only the period. A self-clearing set-value bit lets software load the comparator itself. A narrow one-shot channel also fires when the low half of the counter rolls over from all ones to zero.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the comparator reads all ones and the period reads zero. The low configuration bits read zero, `fire_o` is 0, and the capability bits described in R2 read 1.
- R2: Configuration low-half bit positions are: 0 channel enable, 1 periodic, 2 narrow (half-width), 3 set-value. All other written bits are ignored. On `cfg_rd_o`, bit HALF_W reads 1 (periodic capable) and bit HALF_W+1 reads 1 (full-width capable). The remaining bits read 0.
- R3: `fire_o` is 1 for exactly the cycle after a clock edge at which the compared counter bits equal the comparator while the channel enable and `glb_en_i` are both 1. The compared bits are the low HALF_W bits in narrow mode and all bits otherwise.
- R4: The set-value bit reads 0 after any write to either comparator half.
- R5: A value written into the period has its top bit forced to 0. In narrow mode that is bit HALF_W-1; in full-width mode it is bit 2*HALF_W-1.
- R6: Writing the configuration with the narrow bit at 1 clears the upper halves of the comparator and the period. While the channel is narrow, a high comparator-half write stores zero.
- R7: A low comparator-half write loads the low comparator half only when the channel is one-shot or set-value is 1. When the channel is periodic, the same write also loads the low period half.
- R8: A high comparator-half write loads the high comparator half when the channel is one-shot or set-value is 1. Otherwise it loads only the high period half.
- R9: While active and periodic with a nonzero period, the comparator adds the period once per clock as long as the counter is not before it. "Not before" means the counter minus the comparator is non-negative in the active width. The sum wraps at HALF_W bits in narrow mode. No comparator write or configuration write may occur in that cycle.
- R10: An active narrow one-shot channel also fires on the cycle after an edge at which the low counter half is zero, when the edge before saw it at all ones.
- R11: With the channel enable or `glb_en_i` at 0 no event fires. A configuration write that clears the enable suppresses an event that would otherwise fire at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 2*HALF_W | Shared main counter value |
| glb_en_i | input | 1 | Global enable of the timer block |
| cfg_we_i | input | 1 | Write strobe, configuration low half |
| cmp_lo_we_i | input | 1 | Write strobe, comparator low half |
| cmp_hi_we_i | input | 1 | Write strobe, comparator high half |
| wdata_i | input | HALF_W | Write data shared by the three strobes |
| fire_o | output | 1 | One-clock expiry strobe |
| cfg_rd_o | output | 2*HALF_W | Configuration readback with capability half |
| cmp_rd_o | output | 2*HALF_W | Comparator readback |
| per_rd_o | output | 2*HALF_W | Period readback |

## Verification
The bench builds the channel with HALF_W = 8, which gives a 16-bit counter. A narrow-mode rollover of the low half therefore comes every 256 counts, so the wrap event of a narrow one-shot channel fits in a short run. So do the wrapped comparator additions of a narrow periodic channel and the masking of each period's top bit. A behavioural model updated every clock sets the expected strobe and all three readbacks. Stimulus includes a counter jump that forces several catch-up additions in a row, and a disable written at the very edge of a match.

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel #(
  parameter int HALF_W = 32,
  localparam int W = 2 * HALF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  count_i,
  input  logic          glb_en_i,
  input  logic          cfg_we_i,
  input  logic          cmp_lo_we_i,
  input  logic          cmp_hi_we_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic          fire_o,
  output logic [W-1:0]  cfg_rd_o,
  output logic [W-1:0]  cmp_rd_o,
  output logic [W-1:0]  per_rd_o
);

  logic en_q, per_q, nar_q, sv_q, fire_q, ones_q;
  logic [W-1:0] cmp_q, prd_q;

  logic              active, match, behind, wrap_hit, hit, kill, wr_cmp;
  logic [HALF_W-1:0] cnt_lo, hi_val, lo_prd, hi_prd;
  logic [W-1:0]      gap, sum, next_cmp;

  assign active   = en_q & glb_en_i;
  assign cnt_lo   = count_i[HALF_W-1:0];
  assign match    = nar_q ? (cnt_lo == cmp_q[HALF_W-1:0]) : (count_i == cmp_q);
  assign gap      = count_i - cmp_q;
  assign behind   = nar_q ? ~gap[HALF_W-1] : ~gap[W-1];
  assign sum      = cmp_q + prd_q;
  assign next_cmp = nar_q ? {{HALF_W{1'b0}}, sum[HALF_W-1:0]} : sum;
  assign wrap_hit = active & nar_q & ~per_q & ones_q & (cnt_lo == '0);
  assign hit      = (active & match) | wrap_hit;
  assign kill     = cfg_we_i & ~wdata_i[0];
  assign wr_cmp   = ~per_q | sv_q;
  assign hi_val   = nar_q ? '0 : wdata_i;
  assign lo_prd   = nar_q ? {1'b0, wdata_i[HALF_W-2:0]} : wdata_i;
  assign hi_prd   = {1'b0, hi_val[HALF_W-2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; per_q <= 1'b0; nar_q <= 1'b0; sv_q <= 1'b0;
      fire_q <= 1'b0; ones_q <= 1'b0;
      cmp_q <= '1; prd_q <= '0;
    end else begin
      fire_q <= hit & ~kill;
      ones_q <= &cnt_lo;
      if (cfg_we_i) begin
        en_q  <= wdata_i[0];
        per_q <= wdata_i[1];
        nar_q <= wdata_i[2];
        sv_q  <= wdata_i[3];
        if (wdata_i[2]) begin
          cmp_q[W-1:HALF_W] <= '0;
          prd_q[W-1:HALF_W] <= '0;
        end
      end else if (cmp_lo_we_i) begin
        if (wr_cmp) cmp_q[HALF_W-1:0] <= wdata_i;
        if (per_q)  prd_q[HALF_W-1:0] <= lo_prd;
        sv_q <= 1'b0;
      end else if (cmp_hi_we_i) begin
        if (wr_cmp) cmp_q[W-1:HALF_W] <= hi_val;
        else        prd_q[W-1:HALF_W] <= hi_prd;
        sv_q <= 1'b0;
      end else if (active && per_q && prd_q != '0 && behind) begin
        cmp_q <= next_cmp;
      end
    end
  end

  assign fire_o   = fire_q;
  assign cmp_rd_o = cmp_q;
  assign per_rd_o = prd_q;
  assign cfg_rd_o = {{(HALF_W-2){1'b0}}, 2'b11, {(HALF_W-4){1'b0}}, sv_q, nar_q, per_q, en_q};

  AST_FIRE_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> $past(en_q & glb_en_i)); // R11
  AST_DISABLE_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && !wdata_i[0]) |=> !fire_q); // R11
  AST_SETVAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we_i && (cmp_lo_we_i || cmp_hi_we_i)) |=> !sv_q); // R4
  AST_PERIOD_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    prd_q[W-1] == 1'b0); // R5
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    nar_q |-> (cmp_q[W-1:HALF_W] == '0 && prd_q[W-1:HALF_W] == '0)); // R6
  AST_ONESHOT_CMP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_q && !cfg_we_i && !cmp_lo_we_i && !cmp_hi_we_i) |=> $stable(cmp_q)); // R9

endmodule

// File: tb/evt_cmp_channel_tb.sv
module evt_cmp_channel_tb;
  localparam int H = 8;
  localparam int W = 2 * H;
  localparam longint HM = (64'd1 << H) - 1;
  localparam longint FM = (64'd1 << W) - 1;
  localparam int CFG = 0, LO = 1, HI = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, gen = 1'b1, cfg_we = 1'b0, lo_we = 1'b0, hi_we = 1'b0;
  logic [W-1:0] cnt = '0;
  logic [H-1:0] wd = '0;
  logic fire;
  logic [W-1:0] cfg_rd, cmp_rd, per_rd;

  evt_cmp_channel #(.HALF_W(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .count_i(cnt), .glb_en_i(gen),
    .cfg_we_i(cfg_we), .cmp_lo_we_i(lo_we), .cmp_hi_we_i(hi_we), .wdata_i(wd),
    .fire_o(fire), .cfg_rd_o(cfg_rd), .cmp_rd_o(cmp_rd), .per_rd_o(per_rd));

  bit m_en, m_per, m_nar, m_sv, m_fire, m_prev1;
  longint m_cmp = FM, m_prd = 0;
  int compared = 0, mismatched = 0;
  string tag = "R1";
  bit cnt_run = 1'b1, done = 1'b0;

  task automatic chk(string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    longint c, lowc, d;
    bit act, eq, wrp, nf, ahead;
    if (!rst_n) begin
      m_en = 0; m_per = 0; m_nar = 0; m_sv = 0; m_fire = 0; m_prev1 = 0;
      m_cmp = FM; m_prd = 0;
      return;
    end
    c = longint'(cnt); lowc = c & HM; d = longint'(wd);
    act = m_en && gen;
    eq  = m_nar ? (lowc == (m_cmp & HM)) : (c == m_cmp);
    wrp = act && m_nar && !m_per && m_prev1 && lowc == 0;
    nf  = ((act && eq) || wrp) && !(cfg_we && !wd[0]);
    if (m_nar) ahead = ((lowc - (m_cmp & HM)) & HM) >= (64'd1 << (H - 1));
    else       ahead = ((c - m_cmp) & FM) >= (64'd1 << (W - 1));
    if (cfg_we) begin
      m_en = wd[0]; m_per = wd[1]; m_nar = wd[2]; m_sv = wd[3];
      if (wd[2]) begin m_cmp &= HM; m_prd &= HM; end
    end else if (lo_we) begin
      if (!m_per || m_sv) m_cmp = (m_cmp & ~HM) | d;
      if (m_per) m_prd = (m_prd & ~HM) | (m_nar ? (d & (HM >> 1)) : d);
      m_sv = 0;
    end else if (hi_we) begin
      longint hv = m_nar ? 0 : d;
      if (!m_per || m_sv) m_cmp = (m_cmp & HM) | (hv << H);
      else                m_prd = (m_prd & HM) | ((hv & (HM >> 1)) << H);
      m_sv = 0;
    end else if (act && m_per && m_prd != 0 && !ahead) begin
      m_cmp = m_nar ? ((m_cmp + m_prd) & HM) : ((m_cmp + m_prd) & FM);
    end
    m_prev1 = (lowc == HM);
    m_fire = nf;
  endtask

  task automatic tick();
    longint ecfg;
    @(posedge clk);
    model_step();
    #1;
    ecfg = (longint'(3) << H) | {m_sv, m_nar, m_per, m_en};
    chk("fire", longint'(fire), longint'(m_fire));
    chk("cfg", longint'(cfg_rd), ecfg);
    chk("cmp", longint'(cmp_rd), m_cmp);
    chk("per", longint'(per_rd), m_prd);
    if (cnt_run) cnt = cnt + 1'b1;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(int kind, logic [H-1:0] d);
    wd = d;
    cfg_we = (kind == CFG); lo_we = (kind == LO); hi_we = (kind == HI);
    tick();
    cfg_we = 1'b0; lo_we = 1'b0; hi_we = 1'b0;
  endtask

  task automatic do_reset(logic [W-1:0] start);
    rst_n = 1'b0; gen = 1'b1;
    run(2);
    rst_n = 1'b1;
    cnt = start;
  endtask

  initial begin
    tag = "R1"; do_reset(16'h0000); run(4);

    tag = "R2"; wr(CFG, 8'hF0); run(2); wr(CFG, 8'h0F); run(2); wr(CFG, 8'h00); run(2);

    tag = "R3"; do_reset(16'h0100);
    wr(LO, 8'h20); wr(HI, 8'h01); wr(CFG, 8'h01); run(60);

    tag = "R11"; do_reset(16'h0000);
    wr(LO, 8'h40); wr(HI, 8'h00); gen = 1'b0; wr(CFG, 8'h01); run(80);
    gen = 1'b1; cnt = 16'h0030; run(4);
    cnt = 16'h0040; wr(CFG, 8'h00); run(4);

    tag = "R7"; do_reset(16'h0000);
    wr(CFG, 8'h02); wr(LO, 8'h55);
    tag = "R8"; wr(HI, 8'h12);
    tag = "R4"; wr(CFG, 8'h0A); wr(LO, 8'h30); wr(HI, 8'h00);
    tag = "R8"; wr(CFG, 8'h0A); wr(HI, 8'h02); run(2);

    tag = "R5"; wr(HI, 8'hFF); wr(CFG, 8'h06); wr(LO, 8'hFF); run(2);

    tag = "R6"; do_reset(16'h0000);
    wr(LO, 8'h34); wr(HI, 8'h12); wr(CFG, 8'h04); wr(HI, 8'hAB); wr(LO, 8'h99); run(2);

    tag = "R9"; do_reset(16'h0000);
    wr(CFG, 8'h0A); wr(HI, 8'h00); wr(CFG, 8'h0A); wr(LO, 8'h10);
    wr(CFG, 8'h03); run(80);
    cnt = cnt + 16'h0060; run(12);
    wr(CFG, 8'h07); run(300);

    tag = "R10"; do_reset(16'h0000);
    wr(LO, 8'h05); wr(CFG, 8'h05);
    cnt = 16'h01F0; run(40);
    cnt = 16'h02F8; run(20);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog %s: actual hung expected finished", tag);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule